// File: doc/BRIEF.md
# Branch direction counter table

This block predicts whether a conditional branch will be taken. It holds 512 two-bit saturating counters in a direct-mapped table. A fetch stage presents a branch address on the predict port and gets back a direction in the same cycle, with no clock edge in between. The raw counter value also comes out, so a consumer can tell a strong prediction from a weak one. When the branch resolves, the execute stage presents the same address and the actual outcome on the train port. The indexed counter then moves one step toward that outcome at the next clock edge.

A mode input selects how the table is indexed. In plain mode the index is the address shifted right by one. In history mode an 8-bit global outcome history is XORed into that index, which lets branches whose outcomes are correlated use separate counters. The history register takes in every trained outcome whichever mode is selected. The block does not predict branch targets. It also does not decide when training happens: that policy belongs to the caller.

Top module: `dir_predictor`

## Requirements
- R1: With hist_en low, the table entry used by a prediction or a training is selected by address bits [9:1]. Bit 0 and bits above 9 have no effect on which entry is used.
- R2: Counter encoding on pred_ctr: 0 is strong not-taken, 1 is weak not-taken, 2 is weak taken, 3 is strong taken. pred_taken is 1 exactly when pred_ctr is 2 or 3.
- R3: A training with trn_taken high raises the indexed counter by one at the next rising edge. A counter already at 3 stays at 3.
- R4: A training with trn_taken low lowers the indexed counter by one at the next rising edge. A counter already at 0 stays at 0.
- R5: While rst_n is low (asynchronous, active low), every counter holds 1 and the history register holds 0, and training is ignored.
- R6: With hist_en high, the entry index is address bits [9:1] XOR the 8-bit history, with the history zero-extended to 9 bits.
- R7: Each training shifts the history left by one at the next rising edge and puts trn_taken into bit 0; the top bit is dropped. This happens in both modes. Without a training the history keeps its value.
- R8: A training's own index uses the history value from before that training's shift.
- R9: When a prediction and a training hit the same entry in the same cycle, pred_ctr and pred_taken show the counter value from before the update.
- R10: With trn_valid low, no counter and no history bit changes, whatever trn_pc and trn_taken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hist_en | input | 1 | 1 selects the history-XOR index, 0 the plain index |
| pred_pc | input | 32 | Branch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 means taken |
| pred_ctr | output | 2 | Counter value behind the prediction |
| trn_valid | input | 1 | Training request this cycle |
| trn_pc | input | 32 | Address of the resolved branch |
| trn_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench drives long runs of the same outcome into one entry, to make sure the counter sticks at 3 and at 0. A design that wraps would flip a strong prediction to its opposite after one further outcome. It aims aliased addresses (same bits [9:1], different bit 0 or high bits) and same-cycle predict-and-train at a single entry. A wrong index slice would leave aliases untrained, and a write-through read would show the updated counter one cycle early. In history mode it runs trains with mixed outcomes under mixed modes and compares every prediction against a reference model. A design that used the shifted history for its own training index, or shifted only in history mode, would be caught when later predictions land on the wrong counters.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // One step of a two-bit saturating counter toward the outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken && cur != CTR_ST) nxt = cur + 2'd1;
    else if (!taken && cur != CTR_SNT) nxt = cur - 2'd1;
    return nxt;
  endfunction

  // Direction implied by a counter: upper half means taken.
  function automatic logic ctr_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int IDX_W  = 9,
  parameter int HIST_W = 8
) (
  input  logic [IDX_W-1:0]  pc_bits,
  input  logic [HIST_W-1:0] hist,
  input  logic              hist_en,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] hist_ext;

  generate
    if (HIST_W >= IDX_W) begin : g_wide
      logic [HIST_W-1:0] unused_hist;
      assign unused_hist = hist;
      assign hist_ext    = hist[IDX_W-1:0];
    end else begin : g_narrow
      assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist};
    end
  endgenerate

  assign idx = hist_en ? (pc_bits ^ hist_ext) : pc_bits;

endmodule

// File: rtl/bht_hist.sv
module bht_hist #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
  end

  assert_hist_newbit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist[0] == $past(bit_in));

  assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]));

  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));

endmodule

// File: rtl/bht_table.sv
module bht_table
  import bht_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int ENTRIES = 1 << IDX_W;

  ctr_t cnt [ENTRIES];
  ctr_t wr_old;
  ctr_t wr_new;

  assign wr_old = cnt[wr_idx];
  assign wr_new = ctr_step(wr_old, wr_taken);
  assign rd_ctr = cnt[rd_idx];

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  cnt[e] <= CTR_WNT;
        else if (wr_en && wr_idx == IDX_W'(e))       cnt[e] <= wr_new;
      end
    end
  endgenerate

  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && wr_old != CTR_ST |=> cnt[$past(wr_idx)] == $past(wr_old) + 2'd1);

  assert_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && wr_old == CTR_ST |=> cnt[$past(wr_idx)] == CTR_ST);

  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken && wr_old != CTR_SNT |=> cnt[$past(wr_idx)] == $past(wr_old) - 2'd1);

  assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken && wr_old == CTR_SNT |=> cnt[$past(wr_idx)] == CTR_SNT);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> cnt[$past(rd_idx)] == $past(rd_ctr));

endmodule

// File: rtl/dir_predictor.sv
module dir_predictor
  import bht_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 9,
  parameter int HIST_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hist_en,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic [1:0]      pred_ctr,
  input  logic            trn_valid,
  input  logic [PC_W-1:0] trn_pc,
  input  logic            trn_taken
);

  localparam int LO = 1;
  localparam int HI = IDX_W;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  pred_idx;
  logic [IDX_W-1:0]  trn_idx;
  ctr_t              rd_ctr;

  logic [2*(PC_W-IDX_W)-1:0] unused_pc;
  assign unused_pc = {pred_pc[PC_W-1:HI+1], pred_pc[0], trn_pc[PC_W-1:HI+1], trn_pc[0]};

  bht_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_pidx (
    .pc_bits (pred_pc[HI:LO]),
    .hist    (hist),
    .hist_en (hist_en),
    .idx     (pred_idx)
  );

  // Training index sees the history before this training shifts it (R8).
  bht_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_tidx (
    .pc_bits (trn_pc[HI:LO]),
    .hist    (hist),
    .hist_en (hist_en),
    .idx     (trn_idx)
  );

  bht_hist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (trn_valid),
    .bit_in   (trn_taken),
    .hist     (hist)
  );

  bht_table #(.IDX_W(IDX_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (pred_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (trn_valid),
    .wr_idx   (trn_idx),
    .wr_taken (trn_taken)
  );

  assign pred_ctr   = rd_ctr;
  assign pred_taken = ctr_taken(rd_ctr);

  assert_plain_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_en |-> pred_idx == pred_pc[HI:LO] && trn_idx == trn_pc[HI:LO]);

  // Both ports fold in the same history, so it cancels between them.
  assert_hist_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hist_en |-> (pred_idx ^ trn_idx) == (pred_pc[HI:LO] ^ trn_pc[HI:LO]));

endmodule

// File: tb/sim_dir_predictor.sv
`timescale 1ns/1ps
module sim_dir_predictor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hist_en = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic [1:0]  pred_ctr;
  logic        trn_valid = 1'b0;
  logic [31:0] trn_pc = '0;
  logic        trn_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_ctr [512];
  int m_hist = 0;

  always #2.5 clk = ~clk;

  dir_predictor u0 (
    .clk(clk), .rst_n(rst_n), .hist_en(hist_en),
    .pred_pc(pred_pc), .pred_taken(pred_taken), .pred_ctr(pred_ctr),
    .trn_valid(trn_valid), .trn_pc(trn_pc), .trn_taken(trn_taken)
  );

  function automatic int m_index(input logic [31:0] pc, input bit hen);
    int base;
    base = int'(pc >> 1) & 511;
    if (hen) base = (base ^ m_hist) & 511;
    return base;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare the combinational
  // prediction, then advance the model at the rising edge.
  task automatic cyc(input bit hen, input logic [31:0] ppc, input bit tv,
                     input logic [31:0] tpc, input bit tk, input string tag);
    int pi;
    int ti;
    @(negedge clk);
    hist_en = hen; pred_pc = ppc; trn_valid = tv; trn_pc = tpc; trn_taken = tk;
    #1;
    pi = m_index(ppc, hen);
    check({tag, " ctr"}, int'(pred_ctr), m_ctr[pi]);
    check({tag, " dir R2"}, int'(pred_taken), (m_ctr[pi] >= 2) ? 1 : 0);
    @(posedge clk);
    if (rst_n && tv) begin
      ti = m_index(tpc, hen);          // pre-shift history, R8
      if (tk && m_ctr[ti] < 3) m_ctr[ti]++;
      else if (!tk && m_ctr[ti] > 0) m_ctr[ti]--;
      m_hist = ((m_hist << 1) | (tk ? 1 : 0)) & 255;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    for (int i = 0; i < 512; i++) m_ctr[i] = 1;
    a = 32'h0000_0124;

    // R5: reset holds weak not-taken, training ignored while in reset
    cyc(0, a, 1, a, 1, "R5");
    cyc(1, 32'h0000_0ff0, 1, a, 1, "R5");
    cyc(0, 32'h0000_03fe, 0, a, 0, "R5");
    @(negedge clk);
    rst_n = 1'b1;

    // R3: climb and stick at 3
    for (int i = 0; i < 5; i++) cyc(0, a, 1, a, 1, "R3 R9");
    cyc(0, a, 0, a, 0, "R3");
    // R10: no training, outcome lines wiggle
    for (int i = 0; i < 3; i++) cyc(0, a, 0, a, i[0], "R10");
    // R4: fall and stick at 0
    for (int i = 0; i < 6; i++) cyc(0, a, 1, a, 0, "R4 R9");
    cyc(0, a, 0, a, 1, "R4");

    // R1: aliases on bits [9:1]
    cyc(0, a | 32'h1, 1, a | 32'hF000_0400, 1, "R1");
    cyc(0, a, 1, a | 32'h1, 1, "R1");
    cyc(0, a | 32'h0001_0000, 0, a, 0, "R1");
    cyc(0, a + 32'd2, 0, a, 0, "R1");

    // R6 R7 R8: history mode, mixed outcomes on one address
    for (int i = 0; i < 40; i++)
      cyc(1, 32'h0000_0200 + 32'(2 * (i % 3)), 1, 32'h0000_0200, (i % 3) != 2, "R6 R8");
    // R7: plain-mode trains still shift history, then read in history mode
    for (int i = 0; i < 10; i++) cyc(0, 32'h0000_0040, 1, 32'h0000_0040, i[1], "R7");
    for (int i = 0; i < 10; i++) cyc(1, 32'(i * 2), 0, 32'h0, 1, "R7");

    // mixed sweep
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] p;
      logic [31:0] t;
      bit hen;
      p = $urandom();
      t = ($urandom_range(0, 3) == 0) ? p : ($urandom() & 32'h0000_00fe);
      hen = (i / 500) % 2 == 1;
      cyc(hen, p, $urandom_range(0, 4) != 0, t, $urandom_range(0, 2) != 0,
          hen ? "R6 R7 R8" : "R1 R3 R4");
    end

    // final sweep of every entry in plain mode
    for (int i = 0; i < 512; i++) cyc(0, 32'(i * 2), 0, 32'h0, 0, "R1 R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule